// File: doc/BRIEF.md
# GPIO Port Data and Direction Registers

This block is a memory-mapped general-purpose I/O port. Each of its pins has one bit in each of three registers: a driven-value register, a direction register and a synchronized copy of the pad level. Software reaches the registers over a word-wide bus with an address, a write strobe, write data and a combinational read-data return.

Three write-only alias addresses change bits of the driven-value register in one bus write. One alias sets bits, one clears them and one inverts them, in each case only where the written mask holds a 1. Software therefore never needs a read-modify-write sequence to change a single pin. A pad is driven by its bit of the driven-value register whenever its direction bit is 1. The pad level is passed through a synchronizer before software can read it. The driven-value register can still be read back, so software sees both what it drives and what the pad actually carries.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, the driven-value and direction registers are all zeros, so `pad_oe` and `pad_out` are 0 and every pin is an input.
- R2: A write to byte address 0x00 loads the driven-value register with `wr_data`. A read of 0x00 returns the register's contents.
- R3: A write to address 0x04 sets to 1 every driven-value bit whose `wr_data` bit is 1 and leaves the other bits unchanged.
- R4: A write to address 0x08 clears to 0 every driven-value bit whose `wr_data` bit is 1 and leaves the other bits unchanged.
- R5: A write to address 0x0C inverts every driven-value bit whose `wr_data` bit is 1 and leaves the other bits unchanged.
- R6: A write to address 0x14 loads the direction register, and a read of 0x14 returns it. Bit n set to 1 makes pin n an output, so `pad_oe[n]` equals direction bit n. `pad_out` always equals the driven-value register.
- R7: A read of address 0x10 returns `pad_in` as it was two rising clock edges earlier, through a two-flop synchronizer. A write to 0x10 changes no register.
- R8: Reads of the set, clear and toggle aliases (0x04, 0x08, 0x0C) return zero.
- R9: Any address other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 is unmapped, including misaligned ones such as 0x02. A write to an unmapped address changes no register, and a read from one returns zero.
- R10: A read of 0x00 returns the driven value even where the pad level differs from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | ADDR_W (8) | Byte address of the register being accessed |
| wr_en | input | 1 | Write strobe, sampled on the clock edge |
| wr_data | input | PINS (32) | Write data or bit mask |
| rd_data | output | PINS (32) | Combinational read data for `addr` |
| pad_in | input | PINS (32) | Asynchronous pad levels |
| pad_out | output | PINS (32) | Value driven onto each pad |
| pad_oe | output | PINS (32) | Output enable for each pad; 1 means output |

## Verification
The bench aims at the alias writes with random masks on top of random register contents. A decoder that swapped the set and clear aliases, or that made toggle overwrite the register, would leave the driven-value readback different from the bench's model.

Directed cases cover the following:
- A write to the read-only pin register, which must leave outputs untouched.
- Misaligned and out-of-range addresses, where an incomplete decode would alias a real register.
- Alias reads, which must return zero and not the driven value.

The pin path is checked edge by edge. A missing synchronizer stage shows the new level one cycle early, and an extra stage shows it one cycle late. Driven readback is also checked while the pads carry the opposite levels, which exposes a read mux that returns pad levels where it should return the driven value.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;

   // register selected by the current bus address
   typedef enum logic [2:0] {
      SEL_NONE = 3'd0,
      SEL_DRV  = 3'd1,
      SEL_SET  = 3'd2,
      SEL_CLR  = 3'd3,
      SEL_TGL  = 3'd4,
      SEL_PIN  = 3'd5,
      SEL_DIR  = 3'd6
   } reg_sel_e;

   // byte offsets seen by software
   localparam logic [7:0] OFS_DRV = 8'h00;
   localparam logic [7:0] OFS_SET = 8'h04;
   localparam logic [7:0] OFS_CLR = 8'h08;
   localparam logic [7:0] OFS_TGL = 8'h0C;
   localparam logic [7:0] OFS_PIN = 8'h10;
   localparam logic [7:0] OFS_DIR = 8'h14;

   localparam int unsigned MIN_ADDR_W = 5;

endpackage

// File: rtl/gpio_addr_dec.sv
`timescale 1ns/1ps
module gpio_addr_dec
   import gpio_port_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);

   localparam int unsigned OFS_W = 8;

   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr_w
      $error("gpio_addr_dec: ADDR_W must cover offset 0x14");
   end

   logic [ADDR_W-1:0] a_drv, a_set, a_clr, a_tgl, a_pin, a_dir;

   if (ADDR_W >= OFS_W) begin : g_wide
      assign a_drv = ADDR_W'(OFS_DRV);
      assign a_set = ADDR_W'(OFS_SET);
      assign a_clr = ADDR_W'(OFS_CLR);
      assign a_tgl = ADDR_W'(OFS_TGL);
      assign a_pin = ADDR_W'(OFS_PIN);
      assign a_dir = ADDR_W'(OFS_DIR);
   end else begin : g_narrow
      assign a_drv = OFS_DRV[ADDR_W-1:0];
      assign a_set = OFS_SET[ADDR_W-1:0];
      assign a_clr = OFS_CLR[ADDR_W-1:0];
      assign a_tgl = OFS_TGL[ADDR_W-1:0];
      assign a_pin = OFS_PIN[ADDR_W-1:0];
      assign a_dir = OFS_DIR[ADDR_W-1:0];
   end

   always_comb begin
      sel = SEL_NONE;
      if (addr == a_drv) sel = SEL_DRV;
      if (addr == a_set) sel = SEL_SET;
      if (addr == a_clr) sel = SEL_CLR;
      if (addr == a_tgl) sel = SEL_TGL;
      if (addr == a_pin) sel = SEL_PIN;
      if (addr == a_dir) sel = SEL_DIR;
   end

endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
   parameter int unsigned PINS        = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PINS-1:0] d_async,
   output logic [PINS-1:0] q_sync
);

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: SYNC_STAGES must be at least 2");
   end

   logic [PINS-1:0] stage_q [SYNC_STAGES];

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q_sync = stage_q[SYNC_STAGES-1];

endmodule

// File: rtl/gpio_out_reg.sv
`timescale 1ns/1ps
module gpio_out_reg
   import gpio_port_pkg::*;
#(
   parameter int unsigned PINS = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  reg_sel_e        sel,
   input  logic            wr_en,
   input  logic [PINS-1:0] wr_data,
   output logic [PINS-1:0] drv_q,
   output logic [PINS-1:0] dir_q
);

   logic [PINS-1:0] drv_d;
   logic            drv_we;

   always_comb begin
      drv_d  = drv_q;
      drv_we = 1'b0;
      if (wr_en) begin
         unique case (sel)
            SEL_DRV: begin drv_d = wr_data;          drv_we = 1'b1; end
            SEL_SET: begin drv_d = drv_q | wr_data;  drv_we = 1'b1; end
            SEL_CLR: begin drv_d = drv_q & ~wr_data; drv_we = 1'b1; end
            SEL_TGL: begin drv_d = drv_q ^ wr_data;  drv_we = 1'b1; end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      drv_q <= '0;
      else if (drv_we) drv_q <= drv_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         dir_q <= '0;
      else if (wr_en && sel == SEL_DIR)   dir_q <= wr_data;
   end

   // R3
   set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_SET) |=> ((drv_q & $past(wr_data)) == $past(wr_data)));

   // R4
   clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_CLR) |=> ((drv_q & $past(wr_data)) == '0));

   // R5
   tgl_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_TGL) |=> (drv_q == ($past(drv_q) ^ $past(wr_data))));

   // R9
   drv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (sel == SEL_DRV || sel == SEL_SET || sel == SEL_CLR || sel == SEL_TGL))
      |=> $stable(drv_q));

   // R9
   dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && sel == SEL_DIR) |=> $stable(dir_q));

endmodule

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int unsigned PINS        = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [PINS-1:0]   wr_data,
   output logic [PINS-1:0]   rd_data,
   input  logic [PINS-1:0]   pad_in,
   output logic [PINS-1:0]   pad_out,
   output logic [PINS-1:0]   pad_oe
);

   if (PINS < 1 || PINS > 32) begin : g_bad_pins
      $error("gpio_port_regs: PINS must lie in 1..32");
   end

   reg_sel_e        sel;
   logic [PINS-1:0] drv_q;
   logic [PINS-1:0] dir_q;
   logic [PINS-1:0] pin_q;

   gpio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
      .addr (addr),
      .sel  (sel)
   );

   gpio_out_reg #(.PINS(PINS)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .drv_q   (drv_q),
      .dir_q   (dir_q)
   );

   gpio_in_sync #(.PINS(PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pad_in),
      .q_sync  (pin_q)
   );

   always_comb begin
      unique case (sel)
         SEL_DRV: rd_data = drv_q;
         SEL_PIN: rd_data = pin_q;
         SEL_DIR: rd_data = dir_q;
         default: rd_data = '0;
      endcase
   end

   assign pad_out = drv_q;
   assign pad_oe  = dir_q;

   // R8
   alias_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_SET || sel == SEL_CLR || sel == SEL_TGL) |-> (rd_data == '0));

   // R9
   unmapped_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE) |-> (rd_data == '0));

   // R6
   oe_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_DIR) |-> (rd_data == pad_oe));

   // R10
   drv_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_DRV) |-> (rd_data == pad_out));

endmodule

// File: tb/test_gpio_port_regs.sv
`timescale 1ns/1ps
module test_gpio_port_regs;

   localparam int unsigned PINS   = 32;
   localparam int unsigned ADDR_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic              wr_en = 1'b0;
   logic [PINS-1:0]   wr_data = '0;
   logic [PINS-1:0]   rd_data;
   logic [PINS-1:0]   pad_in = '0;
   logic [PINS-1:0]   pad_out;
   logic [PINS-1:0]   pad_oe;

   int unsigned n_chk  = 0;
   int unsigned n_fail = 0;
   bit          done   = 1'b0;

   logic [PINS-1:0] m_drv = '0;
   logic [PINS-1:0] m_dir = '0;

   always #2 clk = ~clk;

   gpio_port_regs i_gpio_port_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .pad_in  (pad_in),
      .pad_out (pad_out),
      .pad_oe  (pad_oe)
   );

   function automatic logic [PINS-1:0] next_drv(input logic [7:0] a,
                                                input logic [PINS-1:0] old,
                                                input logic [PINS-1:0] d);
      case (a)
         8'h00:   return d;
         8'h04:   return old | d;
         8'h08:   return old & ~d;
         8'h0C:   return old ^ d;
         default: return old;
      endcase
   endfunction

   function automatic logic [PINS-1:0] exp_read(input logic [7:0] a,
                                                input logic [PINS-1:0] pins);
      case (a)
         8'h00:   return m_drv;
         8'h10:   return pins;
         8'h14:   return m_dir;
         default: return '0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [PINS-1:0] act,
                      input logic [PINS-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [PINS-1:0] d);
      @(negedge clk);
      addr    = a;
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
      m_drv   = next_drv(a, m_drv, d);
      if (a == 8'h14) m_dir = d;
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a,
                         input logic [PINS-1:0] exp);
      addr = a;
      #1;
      chk(tag, rd_data, exp);
   endtask

   task automatic pads_chk(input string tag);
      chk({tag, " pad_out"}, pad_out, m_drv);
      chk({tag, " pad_oe"},  pad_oe,  m_dir);
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      pads_chk("R1 reset");
      rd_chk("R1 drv reset", 8'h00, '0);
      rd_chk("R1 dir reset", 8'h14, '0);

      // R2 and R6: plain loads and readback
      wr(8'h00, 32'hA5A5_0F0F);
      rd_chk("R2 drv load", 8'h00, 32'hA5A5_0F0F);
      wr(8'h14, 32'hFFFF_0000);
      rd_chk("R6 dir load", 8'h14, 32'hFFFF_0000);
      pads_chk("R6 pads");

      // R3, R4, R5: directed one-hot and edge masks
      wr(8'h04, 32'h0000_0001);
      rd_chk("R3 set bit0", 8'h00, 32'hA5A5_0F0F);
      wr(8'h04, 32'h8000_0000);
      rd_chk("R3 set bit31", 8'h00, 32'hA5A5_0F0F);
      wr(8'h04, 32'h5A5A_0000);
      rd_chk("R3 set mask", 8'h00, 32'hFFFF_0F0F);
      wr(8'h08, 32'h0000_0F00);
      rd_chk("R4 clear mask", 8'h00, 32'hFFFF_000F);
      wr(8'h0C, 32'hFFFF_FFFF);
      rd_chk("R5 toggle all", 8'h00, 32'h0000_FFF0);
      wr(8'h0C, 32'h0000_0000);
      rd_chk("R5 toggle none", 8'h00, 32'h0000_FFF0);

      // R8: alias reads
      rd_chk("R8 set reads zero", 8'h04, '0);
      rd_chk("R8 clear reads zero", 8'h08, '0);
      rd_chk("R8 toggle reads zero", 8'h0C, '0);

      // R9: unmapped and misaligned writes and reads
      wr(8'h02, 32'hFFFF_FFFF);
      wr(8'h18, 32'h1234_5678);
      wr(8'hFC, 32'hDEAD_BEEF);
      wr(8'h15, 32'h0000_0000);
      rd_chk("R9 drv kept", 8'h00, 32'h0000_FFF0);
      rd_chk("R9 dir kept", 8'h14, 32'hFFFF_0000);
      rd_chk("R9 read 0x02", 8'h02, '0);
      rd_chk("R9 read 0x18", 8'h18, '0);
      rd_chk("R9 read 0xFC", 8'hFC, '0);

      // R7: synchronizer latency, edge by edge
      @(negedge clk);
      pad_in = 32'h0000_0000;
      repeat (3) @(negedge clk);
      pad_in = 32'hC3C3_3C3C;
      rd_chk("R7 before edge", 8'h10, 32'h0000_0000);
      @(negedge clk);
      rd_chk("R7 after one edge", 8'h10, 32'h0000_0000);
      @(negedge clk);
      rd_chk("R7 after two edges", 8'h10, 32'hC3C3_3C3C);

      // R7: write to pin register ignored
      wr(8'h10, 32'hFFFF_FFFF);
      rd_chk("R7 pin write drv", 8'h00, 32'h0000_FFF0);
      rd_chk("R7 pin write dir", 8'h14, 32'hFFFF_0000);
      rd_chk("R7 pin value", 8'h10, 32'hC3C3_3C3C);

      // R10: driven readback with opposite pad levels
      wr(8'h00, 32'h0F0F_F0F0);
      pad_in = 32'hF0F0_0F0F;
      repeat (3) @(negedge clk);
      rd_chk("R10 drv readback", 8'h00, 32'h0F0F_F0F0);
      rd_chk("R10 pin differs", 8'h10, 32'hF0F0_0F0F);

      // random mix, pads held stable so pin register equals pad_in
      for (int i = 0; i < 400; i++) begin
         logic [7:0]      a;
         logic [PINS-1:0] d;
         int unsigned     pick;
         pick = $urandom_range(0, 7);
         case (pick)
            0: a = 8'h00;
            1: a = 8'h04;
            2: a = 8'h08;
            3: a = 8'h0C;
            4: a = 8'h10;
            5: a = 8'h14;
            6: a = 8'h20;
            default: a = 8'h04;
         endcase
         d = $urandom();
         if ($urandom_range(0, 3) == 0) d = 32'h1 << $urandom_range(0, 31);
         wr(a, d);
         case (a)
            8'h04:   rd_chk("R3 random set", 8'h00, m_drv);
            8'h08:   rd_chk("R4 random clear", 8'h00, m_drv);
            8'h0C:   rd_chk("R5 random toggle", 8'h00, m_drv);
            8'h14:   rd_chk("R6 random dir", 8'h14, m_dir);
            8'h10:   rd_chk("R7 random pin", 8'h10, exp_read(8'h10, pad_in));
            8'h20:   rd_chk("R9 random unmapped", 8'h20, '0);
            default: rd_chk("R2 random load", 8'h00, m_drv);
         endcase
         pads_chk("R6 random pads");
      end

      // R1: reset returns everything to inputs
      @(negedge clk);
      rst_n = 1'b0;
      m_drv = '0;
      m_dir = '0;
      #1;
      pads_chk("R1 second reset");
      @(negedge clk);
      rst_n = 1'b1;
      rd_chk("R1 drv after reset", 8'h00, '0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule